// File: doc/BRIEF.md
# BT.656 Video Capture Port

This block receives a byte-wide BT.656 video stream, one sample per clock. Its embedded timing codes are the preamble 0xFF, 0x00, 0x00 followed by a status byte. From these codes the block tracks the field, vertical-blanking and horizontal-blanking state. No separate sync pins exist. Static configuration inputs decide which samples are forwarded. The choices are the active picture or the ancillary data on blanking lines, one field of an interlaced stream or both, even or odd elements or all, and a per-line sample limit and a per-region line limit.

Forwarded samples are packed four to a 32-bit word, with the earliest sample in the low byte. A partial word is flushed at each end-of-active-video code. Words leave on a valid/ready stream toward a DMA engine through a small FIFO. A word that finds the FIFO full is dropped, and a sticky flag records the loss.

Top module: `vcp_capture`

## Requirements
- R1: A timing code is recognised when the previous three bytes were 0xFF, 0x00, 0x00. In the fourth byte (status), bit 6 is the field F, bit 5 is vertical blanking V, and bit 4 is H, with 1 marking end of active video (EAV) and 0 marking start of active video (SAV). `trk_field`, `trk_vblank` and `trk_hblank` take F, V and H on the clock after the status byte is sampled.
- R2: With `cfg_mode`=0, only samples that lie after an SAV and before the next EAV preamble, on lines whose V=0, are forwarded. Blanking bytes, preamble bytes and status bytes are never forwarded.
- R3: With `cfg_mode`=1, only the samples between SAV and the next EAV preamble on lines with V=1 are forwarded. Active-picture lines yield nothing.
- R4: With `cfg_fskip`=1, a sample is forwarded only if the current F equals `cfg_fkeep`.
- R5: The sample index is 0 for the first sample after SAV. With `cfg_eskip`=1, only samples whose index has bit 0 equal to `cfg_epar` are forwarded. For Cb,Y,Cr,Y ordering, `cfg_epar`=1 keeps luma and `cfg_epar`=0 keeps chroma.
- R6: Only samples with index below `cfg_line_len` are forwarded. The index counts every sample on the line, whether or not element skipping drops it.
- R7: Lines are counted from 0 at each SAV whose F,V pair differs from that of the previous SAV. Only lines with a count below `cfg_line_cnt` forward samples.
- R8: Forwarded samples are packed four per word in arrival order, with the first in bits 7:0. A word is presented three clocks after its last sample is sampled.
- R9: On every EAV, a partly filled word is emitted in the same clock, with its unused upper bytes zero.
- R10: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` holds its value. Up to `FIFO_DEPTH` words are kept in order.
- R11: A word produced while the FIFO already holds `FIFO_DEPTH` words is discarded, even if a word is read in that clock. `ovf` then rises and stays high until reset.
- R12: During reset, `m_valid`=0, `ovf`=0, `trk_field`=0, `trk_vblank`=0 and `trk_hblank`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one byte per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_byte | input | 8 | Incoming stream byte |
| cfg_mode | input | 1 | 0 active picture, 1 blanking-line ancillary data |
| cfg_fskip | input | 1 | Enable single-field capture |
| cfg_fkeep | input | 1 | Field value kept when field capture is enabled |
| cfg_eskip | input | 1 | Enable element skipping |
| cfg_epar | input | 1 | Index parity kept when skipping elements |
| cfg_line_len | input | IDX_W (12) | Samples per line considered |
| cfg_line_cnt | input | LCNT_W (11) | Lines per field region considered |
| m_data | output | 8*WORD_BYTES (32) | Packed output word |
| m_valid | output | 1 | Output word available |
| m_ready | input | 1 | Consumer accepts the word |
| ovf | output | 1 | Sticky lost-word flag |
| trk_field | output | 1 | Current field F |
| trk_vblank | output | 1 | Current vertical-blanking state V |
| trk_hblank | output | 1 | Current horizontal-blanking state H |

## Verification
Two pairs of functions share a clock edge.

The first pair is the arrival of an EAV status byte and the end of the line. In that one clock, the three preamble bytes still in flight must be cancelled and the partial word must be flushed. Lines of 9 and 10 samples make every EAV carry a partial word, and the reference model checks that no preamble byte leaks into the flushed word.

The second pair is a FIFO write and a read in the same clock. This is provoked by a ready pattern that drops every third cycle and by a long stall that is released near the end of the stream. The model keeps its own word queue and compares validity, data and the overflow flag every clock.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int PRE_LEN = 3;
  localparam int XY_F    = 6;
  localparam int XY_V    = 5;
  localparam int XY_H    = 4;

  function automatic logic is_preamble(input logic [7:0] b_old, input logic [7:0] b_mid,
                                       input logic [7:0] b_new);
    return (b_old == 8'hFF) && (b_mid == 8'h00) && (b_new == 8'h00);
  endfunction

  function automatic logic region_ok(input logic mode_blank, input logic vbl);
    return mode_blank ? vbl : !vbl;
  endfunction

  function automatic logic field_ok(input logic fskip, input logic fkeep, input logic fld);
    return !fskip || (fld == fkeep);
  endfunction

  function automatic logic parity_ok(input logic eskip, input logic epar, input logic idx_lsb);
    return !eskip || (idx_lsb == epar);
  endfunction
endpackage

// File: rtl/vcp_timing.sv
module vcp_timing
  import vcp_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int LCNT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        din,
  output logic              code_hit,
  output logic [7:0]        old_byte,
  output logic              fld,
  output logic              vbl,
  output logic              hbl,
  output logic [IDX_W-1:0]  samp_idx,
  output logic [LCNT_W-1:0] line_idx
);
  logic [7:0] hist [PRE_LEN];
  logic       fv_known;
  logic [1:0] prev_fv;
  logic [1:0] new_fv;
  logic       sav_hit;

  assign code_hit = is_preamble(hist[PRE_LEN-1], hist[1], hist[0]);
  assign old_byte = hist[PRE_LEN-1];
  assign new_fv   = {din[XY_F], din[XY_V]};
  assign sav_hit  = code_hit && !din[XY_H];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PRE_LEN; i++) hist[i] <= 8'h00;
    end else begin
      hist[0] <= din;
      for (int i = 1; i < PRE_LEN; i++) hist[i] <= hist[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld      <= 1'b0;
      vbl      <= 1'b0;
      hbl      <= 1'b1;
      samp_idx <= '0;
      line_idx <= '0;
      fv_known <= 1'b0;
      prev_fv  <= 2'b00;
    end else begin
      if (code_hit) begin
        fld <= din[XY_F];
        vbl <= din[XY_V];
        hbl <= din[XY_H];
      end
      if (sav_hit) begin
        samp_idx <= '0;
        if (!fv_known || (new_fv != prev_fv)) line_idx <= '0;
        else if (line_idx != '1)              line_idx <= line_idx + 1'b1;
        prev_fv  <= new_fv;
        fv_known <= 1'b1;
      end else if (!code_hit && !hbl && (samp_idx != '1)) begin
        samp_idx <= samp_idx + 1'b1;
      end
    end
  end

  // R1
  hblank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_hit |=> (hbl == $past(din[XY_H])));

  // R6
  idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sav_hit |=> (samp_idx == '0));
endmodule

// File: rtl/vcp_packer.sv
module vcp_packer #(
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [7:0]              din,
  input  logic                    flush,
  output logic                    emit,
  output logic [8*WORD_BYTES-1:0] word
);
  localparam int WW     = 8 * WORD_BYTES;
  localparam int FILL_W = $clog2(WORD_BYTES);

  logic [WW-1:0]     acc, nxt_acc;
  logic [FILL_W-1:0] fill, nxt_fill;
  logic              have;

  always_comb begin
    nxt_acc  = acc;
    nxt_fill = fill;
    have     = 1'b0;
    emit     = 1'b0;
    word     = '0;
    if (push) begin
      for (int b = 0; b < WORD_BYTES; b++)
        if (fill == FILL_W'(b)) nxt_acc[b*8 +: 8] = din;
      if (fill == FILL_W'(WORD_BYTES - 1)) begin
        emit     = 1'b1;
        word     = nxt_acc;
        nxt_acc  = '0;
        nxt_fill = '0;
      end else begin
        nxt_fill = fill + 1'b1;
      end
    end
    have = (nxt_fill != '0);
    if (flush && have) begin
      emit     = 1'b1;
      word     = nxt_acc;
      nxt_acc  = '0;
      nxt_fill = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      fill <= '0;
    end else begin
      acc  <= nxt_acc;
      fill <= nxt_fill;
    end
  end

  // R9
  flush_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && emit && !push && (fill == FILL_W'(1))) |-> (word[WW-1:8] == '0));
endmodule

// File: rtl/vcp_fifo.sv
module vcp_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             valid,
  input  logic             ready,
  output logic             ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             wr_ok, rd_ok;

  assign valid = (cnt != '0);
  assign rdata = mem[rp];
  assign wr_ok = push && (cnt < (AW+1)'(DEPTH));
  assign rd_ok = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_ok) begin
        mem[wp] <= wdata;
        wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (wr_ok ? 1'b1 : 1'b0) - (rd_ok ? 1'b1 : 1'b0);
      if (push && !wr_ok) ovf <= 1'b1;
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(rdata)));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf) |-> ovf);

  // R11
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/vcp_capture.sv
module vcp_capture
  import vcp_pkg::*;
#(
  parameter int IDX_W      = 12,
  parameter int LCNT_W     = 11,
  parameter int WORD_BYTES = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              vid_byte,
  input  logic                    cfg_mode,
  input  logic                    cfg_fskip,
  input  logic                    cfg_fkeep,
  input  logic                    cfg_eskip,
  input  logic                    cfg_epar,
  input  logic [IDX_W-1:0]        cfg_line_len,
  input  logic [LCNT_W-1:0]       cfg_line_cnt,
  output logic [8*WORD_BYTES-1:0] m_data,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic                    ovf,
  output logic                    trk_field,
  output logic                    trk_vblank,
  output logic                    trk_hblank
);
  localparam int WW = 8 * WORD_BYTES;

  logic              code_hit;
  logic [7:0]        old_byte;
  logic [IDX_W-1:0]  samp_idx;
  logic [LCNT_W-1:0] line_idx;
  logic              new_cand;
  logic [PRE_LEN-1:0] cand;
  logic              pk_push;
  logic              pk_flush;
  logic              pk_emit;
  logic [WW-1:0]     pk_word;

  vcp_timing #(.IDX_W(IDX_W), .LCNT_W(LCNT_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .din(vid_byte),
    .code_hit(code_hit), .old_byte(old_byte),
    .fld(trk_field), .vbl(trk_vblank), .hbl(trk_hblank),
    .samp_idx(samp_idx), .line_idx(line_idx)
  );

  assign new_cand = !code_hit && !trk_hblank
                 && region_ok(cfg_mode, trk_vblank)
                 && field_ok(cfg_fskip, cfg_fkeep, trk_field)
                 && parity_ok(cfg_eskip, cfg_epar, samp_idx[0])
                 && (samp_idx < cfg_line_len)
                 && (line_idx < cfg_line_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand <= '0;
    end else begin
      cand[0] <= new_cand;
      for (int i = 1; i < PRE_LEN; i++) cand[i] <= cand[i-1] & ~code_hit;
    end
  end

  assign pk_push  = cand[PRE_LEN-1] & ~code_hit;
  assign pk_flush = code_hit & vid_byte[XY_H];

  vcp_packer #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .push(pk_push), .din(old_byte),
    .flush(pk_flush), .emit(pk_emit), .word(pk_word)
  );

  vcp_fifo #(.WIDTH(WW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(pk_emit), .wdata(pk_word),
    .rdata(m_data), .valid(m_valid), .ready(m_ready), .ovf(ovf)
  );

  // R2
  window_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_push |-> !trk_hblank);

  // R2
  no_code_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_hit |=> !cand[0]);
endmodule

// File: tb/sim_vcp_capture.sv
`timescale 1ns/1ps
module sim_vcp_capture;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [7:0]  vid_byte;
  logic        cfg_mode, cfg_fskip, cfg_fkeep, cfg_eskip, cfg_epar;
  logic [11:0] cfg_line_len;
  logic [10:0] cfg_line_cnt;
  logic [31:0] m_data;
  logic        m_valid, m_ready, ovf, trk_field, trk_vblank, trk_hblank;

  vcp_capture #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .vid_byte(vid_byte),
    .cfg_mode(cfg_mode), .cfg_fskip(cfg_fskip), .cfg_fkeep(cfg_fkeep),
    .cfg_eskip(cfg_eskip), .cfg_epar(cfg_epar),
    .cfg_line_len(cfg_line_len), .cfg_line_cnt(cfg_line_cnt),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .ovf(ovf),
    .trk_field(trk_field), .trk_vblank(trk_vblank), .trk_hblank(trk_hblank)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int rmode = 0;

  logic [7:0]  s[$];
  bit          ev_push[];
  logic [31:0] ev_word[];
  logic [2:0]  ev_trk[];

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic put_code(bit f, bit v, bit h);
    s.push_back(8'hFF); s.push_back(8'h00); s.push_back(8'h00);
    s.push_back({1'b1, f, v, h, 4'h0});
  endtask

  task automatic put_line(bit f, bit v, int n, int base);
    put_code(f, v, 1'b1);
    repeat (4) s.push_back(8'h10);
    put_code(f, v, 1'b0);
    for (int i = 0; i < n; i++) s.push_back(8'(8'h20 + ((base + i) % 200)));
  endtask

  task automatic mk_a();
    s.delete();
    put_line(0, 1, 8, 3);  put_line(0, 1, 8, 11);
    put_line(0, 0, 10, 20); put_line(0, 0, 10, 40); put_line(0, 0, 10, 60);
    put_code(0, 0, 1);
    repeat (24) s.push_back(8'h10);
  endtask

  task automatic mk_b();
    s.delete();
    put_line(0, 0, 9, 5);  put_line(0, 0, 9, 30); put_line(0, 0, 9, 55);
    put_line(1, 0, 9, 80); put_line(1, 0, 9, 105); put_line(1, 0, 9, 130);
    put_code(1, 0, 1);
    repeat (24) s.push_back(8'h10);
  endtask

  // behavioural reference: decides every byte's fate from the whole stream
  task automatic build();
    int n;
    bit code[];
    bit dead[];
    bit f, v, h, known, pf, pv;
    int k, ln, cnt;
    logic [31:0] accw;
    n = s.size();
    code = new[n]; dead = new[n];
    ev_push = new[n + 8]; ev_word = new[n + 8]; ev_trk = new[n + 8];
    f = 0; v = 0; h = 1; known = 0; pf = 0; pv = 0; k = 0; ln = 0; cnt = 0; accw = 0;
    for (int j = 3; j < n; j++)
      if (s[j-3] == 8'hFF && s[j-2] == 8'h00 && s[j-1] == 8'h00) begin
        code[j] = 1; dead[j-3] = 1; dead[j-2] = 1; dead[j-1] = 1;
      end
    for (int i = 0; i < n; i++) begin
      if (code[i]) begin
        if (s[i][4]) begin
          if (cnt > 0) begin ev_push[i] = 1; ev_word[i] = accw; accw = 0; cnt = 0; end
        end else begin
          k = 0;
          if (!known || s[i][6] != pf || s[i][5] != pv) ln = 0; else ln++;
          pf = s[i][6]; pv = s[i][5]; known = 1;
        end
        f = s[i][6]; v = s[i][5]; h = s[i][4];
      end else begin
        bit keep;
        keep = !h && (cfg_mode ? v : !v) && (!cfg_fskip || f == cfg_fkeep)
            && (!cfg_eskip || (k % 2) == int'(cfg_epar))
            && (k < int'(cfg_line_len)) && (ln < int'(cfg_line_cnt)) && !dead[i];
        if (!h) k++;
        if (keep) begin
          accw = accw | (32'(s[i]) << (8 * cnt));
          cnt++;
          if (cnt == 4) begin ev_push[i+3] = 1; ev_word[i+3] = accw; accw = 0; cnt = 0; end
        end
      end
      ev_trk[i] = {f, v, h};
    end
  endtask

  task automatic run(string tag);
    logic [31:0] mq[$];
    bit movf;
    int n, got, made;
    movf = 0; got = 0; made = 0;
    build();
    n = s.size();
    for (int c = 0; c < n + 4; c++) begin
      int sz;
      bit pre_v;
      vid_byte = (c < n) ? s[c] : 8'h10;
      m_ready  = (rmode == 0) ? 1'b1 : (rmode == 1) ? (c % 3 != 0) : (c >= n - 16);
      sz = mq.size();
      pre_v = (sz > 0);
      @(posedge clk);
      if (ev_push[c]) begin
        made++;
        if (sz >= DEPTH) movf = 1;
      end
      if (pre_v && m_ready) begin void'(mq.pop_front()); got++; end
      if (ev_push[c] && sz < DEPTH) mq.push_back(ev_word[c]);
      @(negedge clk);
      check(tag, "valid", {31'd0, m_valid}, {31'd0, mq.size() > 0});
      if (m_valid && mq.size() > 0) check(tag, "data", m_data, mq[0]);
      check("R11", "overflow flag", {31'd0, ovf}, {31'd0, movf});
      check("R1", "timing state", {29'd0, trk_field, trk_vblank, trk_hblank},
            {29'd0, ev_trk[(c < n) ? c : n - 1]});
    end
    check(tag, "words produced", {31'd0, made > 0}, 32'd1);
    check(tag, "queue drained", {31'd0, m_valid}, 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vid_byte = 8'h10; m_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12", "valid in reset", {31'd0, m_valid}, 32'd0);
    check("R12", "overflow in reset", {31'd0, ovf}, 32'd0);
    check("R12", "timing in reset", {29'd0, trk_field, trk_vblank, trk_hblank}, 32'd1);
    rst_n = 1'b1;
  endtask

  task automatic defaults();
    cfg_mode = 0; cfg_fskip = 0; cfg_fkeep = 0; cfg_eskip = 0; cfg_epar = 0;
    cfg_line_len = 12'hFFF; cfg_line_cnt = 11'h7FF; rmode = 0;
  endtask

  initial begin
    defaults();
    do_reset(); mk_a(); run("R2 R8 R9");
    defaults(); cfg_mode = 1;
    do_reset(); mk_a(); run("R3");
    defaults(); cfg_fskip = 1; cfg_fkeep = 1;
    do_reset(); mk_b(); run("R4");
    defaults(); cfg_eskip = 1; cfg_epar = 1;
    do_reset(); mk_a(); run("R5");
    defaults(); cfg_line_len = 12'd6;
    do_reset(); mk_a(); run("R6");
    defaults(); cfg_line_cnt = 11'd2;
    do_reset(); mk_b(); run("R7");
    defaults(); rmode = 1;
    do_reset(); mk_b(); run("R10");
    defaults(); rmode = 2;
    do_reset(); mk_b(); run("R11");
    check("R11", "flag set after stall", {31'd0, ovf}, 32'd1);
    defaults();
    do_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule